// File: doc/BRIEF.md
# Downlink Gold Scrambling Sequence Generator

This block produces the complex scrambling sequence that a WCDMA downlink transmitter or receiver multiplies onto its chip stream. Two 18-stage maximal-length shift sequences, one per fixed polynomial, are combined by XOR into a Gold chip. The code number only changes the phase of the first sequence, never the second. The real (I) branch carries the Gold chip at phase i. The imaginary (Q) branch carries the same code at phase i+131072.

A code is chosen by a 13-bit primary index and a 2-bit alternative selector. After a start strobe the block moves the internal registers to the requested phases, then raises `ready`. From then on, every cycle with `chip_en` high delivers the next 32 chips on each branch. Each chip is a signed ±1 value. The sequence is cut at 38400 chips and begins again from its first chip, and a flag marks the word that holds chip 0.

Top module: `scr_code_gen`

## Requirements
- R1: The first sequence is seeded with a single 1 in its oldest stage and 0 in the other 17 stages, and obeys s(i+18) = s(i+7) XOR s(i). With code number 0, the first output word of the I branch, as binary chips with chip j in bit j, equals 0xBC07FFFE.
- R2: The second sequence is seeded with all 18 stages set to 1, whatever the code number, and obeys s(i+18) = s(i+10) XOR s(i+7) XOR s(i+5) XOR s(i).
- R3: I chip i of code n is x((i+n) mod 262143) XOR y(i). Chip j of a word sits in output bits [2j+1:2j], with the earliest chip at j=0. A binary 0 is driven as +1 (2'b01) and a binary 1 as -1 (2'b11).
- R4: Q chip i of code n equals I chip i+131072 of the same code, with phases taken modulo 262143.
- R5: The code number is n = code_k + 8192*alt_sel, where alt_sel 0 is the primary code, 1 the left alternative and 2 the right alternative.
- R6: A start with alt_sel = 3 (code number above 24575) sets code_err and leaves ready low. code_err stays high until a start with a legal selector, which clears it on the next cycle.
- R7: After a start with a legal code, ready goes low on the next cycle and returns high within 4900 cycles. A start also restarts a block that is already running.
- R8: While ready is high and chip_en is low, both outputs hold their value.
- R9: Each cycle with ready and chip_en high advances both branches by exactly 32 chips.
- R10: After the word that ends with chip 38399, the next word is chip 0 again. frame_start is high exactly while ready is high and the presented word starts at chip 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new code using code_k and alt_sel |
| code_k | input | 13 | Primary code index 0..8191 |
| alt_sel | input | 2 | 0 primary, 1 left alternative, 2 right alternative, 3 illegal |
| chip_en | input | 1 | Advance to the next 32-chip word |
| i_chips | output | 64 | 32 I chips, 2-bit signed each |
| q_chips | output | 64 | 32 Q chips, 2-bit signed each |
| frame_start | output | 1 | Presented word begins at chip 0 |
| ready | output | 1 | Outputs are valid |
| code_err | output | 1 | Last start carried an illegal selector |

## Verification
The bench builds both full-period sequences bit by bit and compares every word against them. This catches a wrong tap or a wrong seed, which would diverge within the first few words. It also catches a Q phase that is wrong by any amount, or a code offset that is not a multiple of 32 and was advanced by the wrong residue. The largest legal code (24575) runs through a whole frame. This exposes a restart that comes one word early or late, or that reloads the wrong phase, because chip 0 would not reappear with frame_start. Further directed cases cover an illegal selector, an error that must persist until the next legal start, and a restart in the middle of a frame.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned LFSR_W = 18;
  // tap masks: bit t set means stage s(i+t) feeds the new stage s(i+18)
  localparam logic [LFSR_W-1:0] X_MASK = 18'h00081;  // taps 0,7
  localparam logic [LFSR_W-1:0] Y_MASK = 18'h004A1;  // taps 0,5,7,10
  localparam logic [LFSR_W-1:0] X_SEED = 18'h00001;
  localparam logic [LFSR_W-1:0] Y_SEED = 18'h3FFFF;
  localparam int unsigned N_LANES = 4;  // 0 x/I, 1 x/Q, 2 y/I, 3 y/Q

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREQ = 2'd1,
    ST_ADV  = 2'd2,
    ST_RUN  = 2'd3
  } scr_state_e;
endpackage

// File: rtl/scr_lane.sv
module scr_lane
  import scr_pkg::*;
#(
  parameter int unsigned CHIPS = 32,
  parameter logic [LFSR_W-1:0] SEED = X_SEED,
  parameter logic [LFSR_W-1:0] MASK = X_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             restore,
  input  logic             step_w,
  input  logic             step_1,
  input  logic             mark,
  output logic [CHIPS-1:0] chips
);
  logic [LFSR_W-1:0] s_q, s_n, sv_q, sv_n, s_w;

  function automatic logic [LFSR_W-1:0] adv1(input logic [LFSR_W-1:0] s);
    return {^(s & MASK), s[LFSR_W-1:1]};
  endfunction

  // unrolled word: chips of the current phase and the state CHIPS steps later
  always_comb begin
    logic [LFSR_W-1:0] t;
    t = s_q;
    chips = '0;
    for (int j = 0; j < CHIPS; j++) begin
      chips[j] = t[0];
      t = adv1(t);
    end
    s_w = t;
  end

  always_comb begin
    s_n  = s_q;
    sv_n = sv_q;
    if (load)         s_n = SEED;
    else if (restore) s_n = sv_q;
    else if (step_w)  s_n = s_w;
    else if (step_1)  s_n = adv1(s_q);
    if (mark) sv_n = s_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q  <= SEED;
      sv_q <= SEED;
    end else begin
      s_q  <= s_n;
      sv_q <= sv_n;
    end
  end
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int unsigned CHIPS     = 32,
  parameter int unsigned FRAME_LEN = 38400,
  parameter int unsigned Q_OFS     = 131072,
  parameter int unsigned N_W       = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [N_W-1:0]     code_n,
  input  logic               code_ok,
  input  logic               chip_en,
  output logic               load,
  output logic [N_LANES-1:0] step_w,
  output logic [N_LANES-1:0] step_1,
  output logic               mark,
  output logic               restore,
  output logic               ready,
  output logic               err,
  output logic               frame_first
);
  localparam int unsigned WORDS  = FRAME_LEN / CHIPS;
  localparam int unsigned QWORDS = Q_OFS / CHIPS;
  localparam int unsigned WC_W   = $clog2(WORDS);
  localparam int unsigned QC_W   = $clog2(QWORDS + 1);
  localparam logic [N_W-1:0]  CHIPS_N = N_W'(CHIPS);
  localparam logic [WC_W-1:0] LAST_W  = WC_W'(WORDS - 1);

  scr_state_e        st_q, st_n;
  logic [QC_W-1:0]   qcnt_q, qcnt_n;
  logic [N_W-1:0]    rem_q, rem_n;
  logic [WC_W-1:0]   word_q, word_n;
  logic              err_q, err_n;

  always_comb begin
    st_n    = st_q;
    qcnt_n  = qcnt_q;
    rem_n   = rem_q;
    word_n  = word_q;
    err_n   = err_q;
    load    = 1'b0;
    step_w  = '0;
    step_1  = '0;
    mark    = 1'b0;
    restore = 1'b0;
    if (start) begin
      if (code_ok) begin
        err_n  = 1'b0;
        load   = 1'b1;
        st_n   = ST_PREQ;
        qcnt_n = QC_W'(QWORDS);
        rem_n  = code_n;
        word_n = '0;
      end else begin
        err_n = 1'b1;
        st_n  = ST_IDLE;
      end
    end else begin
      case (st_q)
        ST_PREQ: begin
          step_w = 4'b1010;  // move Q lanes ahead by the branch offset
          qcnt_n = qcnt_q - 1'b1;
          if (qcnt_q == QC_W'(1)) st_n = ST_ADV;
        end
        ST_ADV: begin
          if (rem_q >= CHIPS_N) begin
            step_w = 4'b0011;
            rem_n  = rem_q - CHIPS_N;
          end else if (rem_q != '0) begin
            step_1 = 4'b0011;
            rem_n  = rem_q - 1'b1;
          end else begin
            mark = 1'b1;
            st_n = ST_RUN;
          end
        end
        ST_RUN: begin
          if (chip_en) begin
            if (word_q == LAST_W) begin
              restore = 1'b1;
              word_n  = '0;
            end else begin
              step_w = 4'b1111;
              word_n = word_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      qcnt_q <= '0;
      rem_q  <= '0;
      word_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      qcnt_q <= qcnt_n;
      rem_q  <= rem_n;
      word_q <= word_n;
      err_q  <= err_n;
    end
  end

  assign ready       = (st_q == ST_RUN);
  assign err         = err_q;
  assign frame_first = ready && (word_q == '0);
endmodule

// File: rtl/scr_code_gen.sv
module scr_code_gen
  import scr_pkg::*;
#(
  parameter int unsigned CHIPS     = 32,
  parameter int unsigned FRAME_LEN = 38400,
  parameter int unsigned Q_OFS     = 131072,
  parameter int unsigned K_W       = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [K_W-1:0]     code_k,
  input  logic [1:0]         alt_sel,
  input  logic               chip_en,
  output logic [2*CHIPS-1:0] i_chips,
  output logic [2*CHIPS-1:0] q_chips,
  output logic               frame_start,
  output logic               ready,
  output logic               code_err
);
  localparam int unsigned N_W = K_W + 2;

  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [N_W-1:0]     code_n;
  logic               code_ok;
  logic               load, mark, restore;
  logic [N_LANES-1:0] step_w, step_1;
  logic [CHIPS-1:0]   lane_chips [N_LANES];
  logic [CHIPS-1:0]   i_bits, q_bits;

  assign code_n  = {alt_sel, code_k};
  assign code_ok = (alt_sel != 2'b11);

  scr_ctrl #(
    .CHIPS(CHIPS), .FRAME_LEN(FRAME_LEN), .Q_OFS(Q_OFS), .N_W(N_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_i), .start(start), .code_n(code_n),
    .code_ok(code_ok), .chip_en(chip_en), .load(load), .step_w(step_w),
    .step_1(step_1), .mark(mark), .restore(restore), .ready(ready),
    .err(code_err), .frame_first(frame_start)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    localparam logic [LFSR_W-1:0] L_SEED = (l < 2) ? X_SEED : Y_SEED;
    localparam logic [LFSR_W-1:0] L_MASK = (l < 2) ? X_MASK : Y_MASK;
    scr_lane #(.CHIPS(CHIPS), .SEED(L_SEED), .MASK(L_MASK)) u_lane (
      .clk(clk), .rst_n(rst_i), .load(load), .restore(restore),
      .step_w(step_w[l]), .step_1(step_1[l]), .mark(mark),
      .chips(lane_chips[l])
    );
  end

  assign i_bits = lane_chips[0] ^ lane_chips[2];
  assign q_bits = lane_chips[1] ^ lane_chips[3];

  for (genvar j = 0; j < CHIPS; j++) begin : g_map
    assign i_chips[2*j+1:2*j] = i_bits[j] ? 2'b11 : 2'b01;
    assign q_chips[2*j+1:2*j] = q_bits[j] ? 2'b11 : 2'b01;
  end
endmodule

// File: rtl/scr_code_gen_chk.sv
module scr_code_gen_chk #(
  parameter int unsigned CHIPS     = 32,
  parameter int unsigned FRAME_LEN = 38400
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [1:0]         alt_sel,
  input logic               chip_en,
  input logic [2*CHIPS-1:0] i_chips,
  input logic [2*CHIPS-1:0] q_chips,
  input logic               frame_start,
  input logic               ready,
  input logic               code_err
);
  localparam int unsigned WORDS = FRAME_LEN / CHIPS;
  localparam int unsigned WC_W  = $clog2(WORDS);

  logic [WC_W-1:0]    wcnt;
  logic               cap_v;
  logic [2*CHIPS-1:0] cap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt  <= '0;
      cap_v <= 1'b0;
      cap_i <= '0;
    end else begin
      if (start || !ready) wcnt <= '0;
      else if (chip_en)    wcnt <= (wcnt == WC_W'(WORDS - 1)) ? '0 : wcnt + 1'b1;
      if (start || !ready) cap_v <= 1'b0;
      else if (frame_start && !cap_v) begin
        cap_v <= 1'b1;
        cap_i <= i_chips;
      end
    end
  end

  AST_BAD_CODE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    start && alt_sel == 2'b11 |=> code_err && !ready); // R6
  AST_ERR_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> !ready); // R6
  AST_GOOD_CODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start && alt_sel != 2'b11 |=> !code_err && !ready); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !chip_en && !start |=> $stable(i_chips) && $stable(q_chips)); // R8
  AST_WRAP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ready && chip_en && !start && wcnt == WC_W'(WORDS - 1) |=> frame_start); // R10
  AST_NO_EARLY_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    ready && chip_en && !start && wcnt != WC_W'(WORDS - 1) |=> !frame_start); // R10
  AST_MARK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ready); // R10
  AST_FRAME_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
    ready && frame_start && cap_v |-> i_chips == cap_i); // R10
endmodule

bind scr_code_gen scr_code_gen_chk #(.CHIPS(CHIPS), .FRAME_LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rst_n(rst_i), .start(start), .alt_sel(alt_sel),
  .chip_en(chip_en), .i_chips(i_chips), .q_chips(q_chips),
  .frame_start(frame_start), .ready(ready), .code_err(code_err)
);

// File: tb/tb_scr_code_gen.sv
module tb_scr_code_gen;
  localparam int P     = 262143;
  localparam int HALF  = 131072;
  localparam int WORDS = 1200;

  logic        clk, rst_n, start, chip_en;
  logic [12:0] code_k;
  logic [1:0]  alt_sel;
  logic [63:0] i_chips, q_chips;
  logic        frame_start, ready, code_err;

  int total = 0;
  int bad   = 0;

  bit xs [P];
  bit ys [P];

  scr_code_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_k(code_k),
    .alt_sel(alt_sel), .chip_en(chip_en), .i_chips(i_chips),
    .q_chips(q_chips), .frame_start(frame_start), .ready(ready),
    .code_err(code_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {alt_sel, code_k}
  localparam logic [14:0] VEC [6] = '{
    {2'd0, 13'd0}, {2'd0, 13'd1}, {2'd0, 13'd8191},
    {2'd1, 13'd5}, {2'd2, 13'd100}, {2'd3, 13'd37}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] map32(input logic [31:0] b);
    logic [63:0] r;
    for (int j = 0; j < 32; j++) r[2*j +: 2] = b[j] ? 2'b11 : 2'b01;
    return r;
  endfunction

  function automatic logic [63:0] exp_word(input int n, input int w, input bit q);
    logic [31:0] b;
    for (int j = 0; j < 32; j++) begin
      int i;
      i = w * 32 + j;
      if (q) b[j] = xs[(i + HALF + n) % P] ^ ys[(i + HALF) % P];
      else   b[j] = xs[(i + n) % P] ^ ys[i];
    end
    return map32(b);
  endfunction

  task automatic do_start(input logic [1:0] sel, input logic [12:0] k);
    @(negedge clk);
    alt_sel = sel; code_k = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 1;
    while (!ready && cyc < 6000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic step();
    chip_en = 1'b1;
    @(negedge clk);
    chip_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, n;
    logic [63:0] w0i, held;
    for (int i = 0; i < 18; i++) begin xs[i] = (i == 0); ys[i] = 1'b1; end
    for (int i = 0; i + 18 < P; i++) begin
      xs[i+18] = xs[i+7] ^ xs[i];
      ys[i+18] = ys[i+10] ^ ys[i+7] ^ ys[i+5] ^ ys[i];
    end

    rst_n = 1'b0; start = 1'b0; chip_en = 1'b0; code_k = '0; alt_sel = '0;
    repeat (3) @(negedge clk);
    check("R7 reset ready", {63'd0, ready}, 64'd0);
    check("R6 reset err", {63'd0, code_err}, 64'd0);
    check("R10 reset frame_start", {63'd0, frame_start}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic [1:0] sel;
      sel = VEC[v][14:13];
      n = int'(VEC[v]);
      do_start(sel, VEC[v][12:0]);
      if (sel == 2'b11) begin
        check("R6 err set", {62'd0, code_err, ready}, 64'd2);
        repeat (5) @(negedge clk);
        check("R6 err held", {62'd0, code_err, ready}, 64'd2);
      end else begin
        check("R7 ready low after start", {63'd0, ready}, 64'd0);
        wait_ready(cyc);
        check("R7 ready within bound", {63'd0, (cyc <= 4900)}, 64'd1);
        for (int w = 0; w < 3; w++) begin
          check("R3 I word", i_chips, exp_word(n, w, 1'b0));
          check("R4 Q word", q_chips, exp_word(n, w, 1'b1));
          check("R10 frame_start", {63'd0, frame_start}, {63'd0, (w == 0)});
          step();
        end
      end
    end

    // R1 R2: known first word of code 0; y seed independent of code (R5 alt codes above)
    do_start(2'd0, 13'd0);
    check("R6 err cleared by legal start", {63'd0, code_err}, 64'd0);
    wait_ready(cyc);
    check("R1 R2 first I word", i_chips, map32(32'hBC07FFFE));

    // R8 hold and R9 advance
    step();
    held = i_chips;
    repeat (3) @(negedge clk);
    check("R8 I held", i_chips, held);
    check("R8 I held value", i_chips, exp_word(0, 1, 1'b0));
    step();
    check("R9 one word per enable", i_chips, exp_word(0, 2, 1'b0));

    // R7 restart mid-run
    do_start(2'd1, 13'd3);
    check("R7 restart drops ready", {63'd0, ready}, 64'd0);
    wait_ready(cyc);
    check("R5 left alt word0", i_chips, exp_word(8192 + 3, 0, 1'b0));

    // R10 full frame with largest code
    n = 24575;
    do_start(2'd2, 13'd8191);
    wait_ready(cyc);
    check("R7 max code bound", {63'd0, (cyc <= 4900)}, 64'd1);
    w0i = i_chips;
    check("R5 right alt max word0", i_chips, exp_word(n, 0, 1'b0));
    for (int w = 1; w < WORDS; w++) begin
      step();
      if (i_chips !== exp_word(n, w, 1'b0) || frame_start)
        check("R9 frame word", {i_chips[62:0], frame_start}, {exp_word(n, w, 1'b0)[62:0], 1'b0});
    end
    check("R4 last Q word", q_chips, exp_word(n, WORDS - 1, 1'b1));
    step();
    check("R10 wrap flag", {63'd0, frame_start}, 64'd1);
    check("R10 wrap I", i_chips, w0i);
    check("R10 wrap Q", q_chips, exp_word(n, 0, 1'b1));
    step();
    check("R10 after wrap", i_chips, exp_word(n, 1, 1'b0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule